// File: doc/BRIEF.md
# DRAM Per-Bank Command Sequencer

This block drives a single bank of a DRAM device on behalf of a memory controller. Read and write requests arrive on a valid/ready port and wait in a small in-order queue. The sequencer remembers which row of the bank is open. For the request at the head of the queue it emits activate, read, write or precharge commands on a valid/ready command port, and every command carries the fixed index of this bank. A set of down-counters holds each command back until the bank's timing limits are met.

When the head request targets a different row than the open one, the sequencer looks at the request queued behind it. If that next request also needs a different row and auto-precharge is enabled, the current read or write goes out with the auto-precharge address bit set, so no separate precharge is needed. Otherwise the row is closed later with an explicit precharge. An external refresh requester can ask for the bank. The sequencer closes the open row, grants the refresh, stays silent while the request is held, and then reopens whatever row the queue needs.

Top module: `bank_sequencer`

## Requirements
- R1: Commands are encoded on {cas, ras, we} as read 100, write 101, activate 010, precharge 011. The refresh code 110 and the nop code 000 are never presented with valid high. Exactly one of is_cmd (activate or precharge), is_read and is_write is set on every valid command.
- R2: The bank field of every valid command equals the BANK_IDX parameter.
- R3: The request address is {row, column}, with the row in the upper ROW_W bits. An activate carries the row on the command address. A read or write carries the column shifted left by BURST_LOG2 bits. A precharge carries an all-zero address.
- R4: Reads and writes to the row already open issue no activate. Only one activate is issued for as long as the row stays open.
- R5: With AUTO_PRE=1, a read or write whose queued successor targets a different row has command address bit 10 set. The successor's activate then follows with no precharge in between.
- R6: If the successor is not yet queued when the read or write issues, a later request to a different row gets an explicit precharge and then an activate.
- R7: A precharge becomes valid no earlier than ceil(CWL/NPHASES) + T_WR + T_CCD cycles after the handshake of the last write. It becomes valid exactly then when no other limit applies.
- R8: Spacing limits, each counted from one command's handshake cycle to the first valid cycle of the later command:
  - activate to activate: at least T_RC;
  - activate to precharge: at least T_RAS;
  - activate to read or write: at least T_RCD;
  - read or write to read or write: at least T_CCD;
  - precharge to activate: at least T_RP;
  - auto-precharged write to activate: at least ceil(CWL/NPHASES) + T_WR + T_RP;
  - auto-precharged read to activate: at least T_RP.

  A limit set to 0 or 1 adds no wait.
- R9: While refresh_req is high, an open row is closed by a precharge. refresh_gnt then rises once the row is closed and the precharge time has elapsed. No command is valid while the grant is high. After refresh_req falls, the needed row is activated again.
- R10: req_lock is low after reset. It is high from the cycle after the first accepted request until the cycle after the last queued request completes.
- R11: req_wdata_ready pulses exactly in the handshake cycle of a write command, and req_rdata_valid exactly in the handshake cycle of a read command.
- R12: req_ready is high after reset and low only while the queue holds QDEPTH requests. No accepted request is lost or reordered under back-to-back traffic and command back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W-BURST_LOG2 | {row, column} request address |
| req_lock | output | 1 | Requests still pending in this bank |
| req_wdata_ready | output | 1 | Write completion strobe |
| req_rdata_valid | output | 1 | Read completion strobe |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken |
| cmd_cas | output | 1 | Column strobe bit of the command code |
| cmd_ras | output | 1 | Row strobe bit of the command code |
| cmd_we | output | 1 | Write-enable bit of the command code |
| cmd_ba | output | BANK_W | Bank index |
| cmd_a | output | max(ROW_W,COL_W) | Command address |
| cmd_is_cmd | output | 1 | Command is activate or precharge |
| cmd_is_read | output | 1 | Command is a read |
| cmd_is_write | output | 1 | Command is a write |
| refresh_req | input | 1 | Refresh requested by the refresh timer |
| refresh_gnt | output | 1 | Bank closed and quiet for refresh |

## Verification
The bench goes after the row-change decision at its two edges. In one case the successor is already queued, so a design that ignored the lookahead would emit a needless precharge. In the other case the successor arrives after the queue drained, so a design that assumed auto-precharge would activate on an open row. It measures the write-to-precharge, activate-to-activate, activate-to-precharge and activate-to-read gaps exactly, where an off-by-one counter shows up as a command one cycle early or late. It holds refresh with requests queued, which catches a design that issues commands during refresh or forgets the row it closed. It fills the queue under back-pressure, where a full-flag slip would drop or duplicate a write.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

    // Command code, bit order {cas, ras, we}
    typedef enum logic [2:0] {
        CMD_NOP   = 3'b000,
        CMD_READ  = 3'b100,
        CMD_WRITE = 3'b101,
        CMD_ACT   = 3'b010,
        CMD_PRE   = 3'b011
    } cmd_code_e;

    // Address bit that requests auto-precharge on a column command
    localparam int AUTO_PRE_BIT = 10;

    // Timer slots
    localparam int TM_RCD   = 0;
    localparam int TM_RAS   = 1;
    localparam int TM_RC    = 2;
    localparam int TM_RP    = 3;
    localparam int TM_WR    = 4;
    localparam int TM_CCD   = 5;
    localparam int N_TIMERS = 6;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Loaded with N at a handshake edge, done N cycles after that handshake
    assign done = (cnt <= CNT_W'(1));
endmodule

// File: rtl/bank_req_queue.sv
module bank_req_queue #(
    parameter int W     = 22,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [W-1:0] next,
    output logic         head_valid,
    output logic         next_valid,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   cnt;
    logic             do_pop;

    assign do_pop = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (PTR_W+1)'(push) - (PTR_W+1)'(do_pop);
        end
    end

    assign head       = mem[rd_ptr];
    assign next       = mem[rd_ptr + 1'b1];
    assign head_valid = (cnt != '0);
    assign next_valid = (cnt > (PTR_W+1)'(1));
    assign full       = (cnt == (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/bank_sequencer.sv
module bank_sequencer
    import dram_bank_pkg::*;
#(
    parameter int BANK_IDX   = 0,
    parameter int BANK_W     = 3,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10,
    parameter int BURST_LOG2 = 2,
    parameter int QDEPTH     = 4,
    parameter int CWL        = 2,
    parameter int NPHASES    = 2,
    parameter int T_RCD      = 2,
    parameter int T_RP       = 2,
    parameter int T_RAS      = 0,
    parameter int T_RC       = 0,
    parameter int T_WR       = 2,
    parameter int T_CCD      = 1,
    parameter bit AUTO_PRE   = 1'b1,
    parameter int CNT_W      = 6,
    localparam int CA_W      = COL_W - BURST_LOG2,
    localparam int RA_W      = ROW_W + CA_W,
    localparam int A_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [RA_W-1:0]   req_addr,
    output logic              req_lock,
    output logic              req_wdata_ready,
    output logic              req_rdata_valid,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_cas,
    output logic              cmd_ras,
    output logic              cmd_we,
    output logic [BANK_W-1:0] cmd_ba,
    output logic [A_W-1:0]    cmd_a,
    output logic              cmd_is_cmd,
    output logic              cmd_is_read,
    output logic              cmd_is_write,
    input  logic              refresh_req,
    output logic              refresh_gnt
);
    localparam int WLAT        = ceil_div(CWL, NPHASES);
    localparam int WR_TO_PRE   = WLAT + T_WR + T_CCD;
    localparam int WR_AP_CLOSE = WLAT + T_WR + T_RP;
    localparam int ENT_W       = RA_W + 1;

    // Queue
    logic [ENT_W-1:0] head, next;
    logic             head_valid, next_valid, q_full, q_pop;

    bank_req_queue #(.W(ENT_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push(req_valid && req_ready), .push_data({req_we, req_addr}),
        .pop(q_pop),
        .head(head), .next(next),
        .head_valid(head_valid), .next_valid(next_valid), .full(q_full)
    );

    logic             head_we;
    logic [ROW_W-1:0] head_row, next_row;
    logic [CA_W-1:0]  head_col;
    assign head_we  = head[RA_W];
    assign head_row = head[RA_W-1:CA_W];
    assign head_col = head[CA_W-1:0];
    assign next_row = next[RA_W-1:CA_W];

    // Timers
    logic [N_TIMERS-1:0] t_load, t_done;
    logic [CNT_W-1:0]    t_val [N_TIMERS];

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
        bank_gap_timer #(.CNT_W(CNT_W)) u_timer (
            .clk(clk), .rst(rst),
            .load(t_load[g]), .load_val(t_val[g]), .done(t_done[g])
        );
    end

    // Open-row state
    logic             row_open;
    logic [ROW_W-1:0] open_row;
    logic             row_hit, use_ap;
    cmd_code_e        code;
    logic [A_W-1:0]   addr_c;
    logic             fire;

    assign row_hit = row_open && (open_row == head_row);

    always_comb begin
        code   = CMD_NOP;
        addr_c = '0;
        use_ap = 1'b0;
        if (refresh_req) begin
            if (row_open && t_done[TM_RAS] && t_done[TM_WR])
                code = CMD_PRE;
        end else if (head_valid) begin
            if (!row_open) begin
                if (t_done[TM_RP] && t_done[TM_RC]) begin
                    code   = CMD_ACT;
                    addr_c = A_W'(head_row);
                end
            end else if (!row_hit) begin
                if (t_done[TM_RAS] && t_done[TM_WR])
                    code = CMD_PRE;
            end else if (t_done[TM_RCD] && t_done[TM_CCD]) begin
                code   = head_we ? CMD_WRITE : CMD_READ;
                use_ap = AUTO_PRE && next_valid && (next_row != head_row);
                addr_c = A_W'({head_col, {BURST_LOG2{1'b0}}});
                addr_c[AUTO_PRE_BIT] = use_ap;
            end
        end
    end

    assign cmd_valid = (code != CMD_NOP);
    assign fire      = cmd_valid && cmd_ready;
    assign q_pop     = fire && (code == CMD_READ || code == CMD_WRITE);

    always_comb begin
        t_load = '0;
        for (int k = 0; k < N_TIMERS; k++) t_val[k] = '0;
        t_val[TM_RCD] = CNT_W'(T_RCD);
        t_val[TM_RAS] = CNT_W'(T_RAS);
        t_val[TM_RC]  = CNT_W'(T_RC);
        t_val[TM_WR]  = CNT_W'(WR_TO_PRE);
        t_val[TM_CCD] = CNT_W'(T_CCD);
        t_val[TM_RP]  = (use_ap && head_we) ? CNT_W'(WR_AP_CLOSE) : CNT_W'(T_RP);
        if (fire) begin
            t_load[TM_RCD] = (code == CMD_ACT);
            t_load[TM_RAS] = (code == CMD_ACT);
            t_load[TM_RC]  = (code == CMD_ACT);
            t_load[TM_RP]  = (code == CMD_PRE) || use_ap;
            t_load[TM_WR]  = (code == CMD_WRITE);
            t_load[TM_CCD] = q_pop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (fire) begin
            if (code == CMD_ACT) begin
                row_open <= 1'b1;
                open_row <= head_row;
            end else if (code == CMD_PRE || use_ap) begin
                row_open <= 1'b0;
            end
        end
    end

    // Outputs
    assign {cmd_cas, cmd_ras, cmd_we} = code;
    assign cmd_a           = addr_c;
    assign cmd_ba          = BANK_W'(BANK_IDX);
    assign cmd_is_cmd      = (code == CMD_ACT) || (code == CMD_PRE);
    assign cmd_is_read     = (code == CMD_READ);
    assign cmd_is_write    = (code == CMD_WRITE);
    assign req_ready       = !q_full;
    assign req_lock        = head_valid;
    assign req_wdata_ready = fire && (code == CMD_WRITE);
    assign req_rdata_valid = fire && (code == CMD_READ);
    assign refresh_gnt     = refresh_req && !row_open && t_done[TM_RP];
endmodule

// File: rtl/bank_sequencer_checker.sv
module bank_sequencer_checker #(
    parameter int T_RC  = 0,
    parameter int T_RAS = 0
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic req_lock,
    input logic req_wdata_ready,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_cas,
    input logic cmd_ras,
    input logic cmd_we,
    input logic cmd_is_cmd,
    input logic cmd_is_read,
    input logic cmd_is_write,
    input logic refresh_req,
    input logic refresh_gnt
);
    logic        act_v, pre_v, seen_act;
    logic [15:0] since_act;

    assign act_v = cmd_valid && !cmd_cas &&  cmd_ras && !cmd_we;
    assign pre_v = cmd_valid && !cmd_cas &&  cmd_ras &&  cmd_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_act  <= 1'b0;
            since_act <= '0;
        end else if (act_v && cmd_ready) begin
            seen_act  <= 1'b1;
            since_act <= 16'd1;
        end else if (since_act != 16'hffff) begin
            since_act <= since_act + 16'd1;
        end
    end

    assert_one_flag_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $countones({cmd_is_cmd, cmd_is_read, cmd_is_write}) == 1);

    assert_no_refresh_code_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !(cmd_cas && cmd_ras));

    assert_act_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        (act_v && seen_act) |-> (since_act >= 16'(T_RC)));

    assert_act_to_pre_R8: assert property (@(posedge clk) disable iff (rst)
        (pre_v && seen_act) |-> (since_act >= 16'(T_RAS)));

    assert_quiet_when_granted_R9: assert property (@(posedge clk) disable iff (rst)
        refresh_gnt |-> !cmd_valid);

    assert_grant_needs_request_R9: assert property (@(posedge clk) disable iff (rst)
        refresh_gnt |-> refresh_req);

    assert_lock_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> req_lock);

    assert_write_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        req_wdata_ready |-> (cmd_valid && cmd_ready && cmd_is_write));
endmodule

bind bank_sequencer bank_sequencer_checker #(.T_RC(T_RC), .T_RAS(T_RAS)) u_checker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_lock(req_lock),
    .req_wdata_ready(req_wdata_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cas(cmd_cas), .cmd_ras(cmd_ras), .cmd_we(cmd_we),
    .cmd_is_cmd(cmd_is_cmd), .cmd_is_read(cmd_is_read), .cmd_is_write(cmd_is_write),
    .refresh_req(refresh_req), .refresh_gnt(refresh_gnt)
);

// File: tb/test_bank_sequencer.sv
module test_bank_sequencer;
    localparam int BANK_IDX = 5;
    localparam int BANK_W   = 3;
    localparam int ROW_W    = 13;
    localparam int COL_W    = 10;
    localparam int BL2      = 2;
    localparam int CA_W     = COL_W - BL2;
    localparam int RA_W     = ROW_W + CA_W;
    localparam int A_W      = 13;
    localparam int QD       = 4;
    localparam int T_RCD = 2, T_RP = 2, T_RAS = 12, T_RC = 16, T_WR = 6, T_CCD = 4;
    localparam int WLAT     = 1;                  // ceil(2/2)
    localparam int GAP_WP   = WLAT + T_WR + T_CCD; // 11
    localparam int GAP_APW  = WLAT + T_WR + T_RP;  // 9
    localparam logic [2:0] C_RD = 3'b100, C_WR = 3'b101, C_ACT = 3'b010, C_PRE = 3'b011;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, req_valid, req_ready, req_we, req_lock, req_wdata_ready, req_rdata_valid;
    logic [RA_W-1:0] req_addr;
    logic cmd_valid, cmd_ready, cmd_cas, cmd_ras, cmd_we;
    logic [BANK_W-1:0] cmd_ba;
    logic [A_W-1:0] cmd_a;
    logic cmd_is_cmd, cmd_is_read, cmd_is_write, refresh_req, refresh_gnt;

    bank_sequencer #(
        .BANK_IDX(BANK_IDX), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .BURST_LOG2(BL2), .QDEPTH(QD), .CWL(2), .NPHASES(2),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_WR(T_WR), .T_CCD(T_CCD), .AUTO_PRE(1'b1), .CNT_W(6)
    ) i_bank_sequencer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_lock(req_lock), .req_wdata_ready(req_wdata_ready), .req_rdata_valid(req_rdata_valid),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_cas(cmd_cas), .cmd_ras(cmd_ras), .cmd_we(cmd_we),
        .cmd_ba(cmd_ba), .cmd_a(cmd_a),
        .cmd_is_cmd(cmd_is_cmd), .cmd_is_read(cmd_is_read), .cmd_is_write(cmd_is_write),
        .refresh_req(refresh_req), .refresh_gnt(refresh_gnt)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected command stream
    logic [2:0]     q_code[$];
    logic [A_W-1:0] q_addr[$];

    // Batch description and bench row model
    bit             b_we  [16];
    logic [ROW_W-1:0] b_row [16];
    logic [CA_W-1:0]  b_col [16];
    bit             m_open = 0;
    logic [ROW_W-1:0] m_row = '0;

    task automatic model_batch(input int n);
        for (int i = 0; i < n; i++) begin
            bit ap;
            logic [A_W-1:0] a;
            if (m_open && m_row != b_row[i]) begin
                q_code.push_back(C_PRE); q_addr.push_back('0);
                m_open = 0;
            end
            if (!m_open) begin
                q_code.push_back(C_ACT); q_addr.push_back(A_W'(b_row[i]));
                m_open = 1; m_row = b_row[i];
            end
            ap = (i < n - 1) && (b_row[i+1] != b_row[i]);
            a = A_W'({b_col[i], 2'b00});
            a[10] = ap;
            q_code.push_back(b_we[i] ? C_WR : C_RD); q_addr.push_back(a);
            if (ap) m_open = 0;
        end
    endtask

    // Command-ready driver: 0 hold low, 1 always, 2 random
    int rmode = 0;
    initial begin
        cmd_ready = 0;
        forever begin
            @(posedge clk); #1;
            case (rmode)
                0: cmd_ready = 0;
                1: cmd_ready = 1;
                default: cmd_ready = (($urandom % 3) != 0);
            endcase
        end
    end

    task automatic push_req(input bit we, input logic [ROW_W-1:0] row, input logic [CA_W-1:0] col);
        bit ok;
        @(posedge clk); #1;
        req_valid = 1; req_we = we; req_addr = {row, col};
        do begin
            @(negedge clk); ok = req_ready;
            @(posedge clk); #1;
        end while (!ok);
        req_valid = 0;
    endtask

    task automatic wait_done(input int lim);
        int k = 0;
        do begin @(negedge clk); k++; end
        while (!(q_code.size() == 0 && !req_lock) && k < lim);
        chk(k < lim, "R12 all requests completed", k, lim);
        chk(!req_lock, "R10 lock released", req_lock, 0);
    endtask

    task automatic run_batch(input int n, input int mode);
        model_batch(n);
        rmode = 0;
        for (int i = 0; i < n; i++) push_req(b_we[i], b_row[i], b_col[i]);
        @(negedge clk);
        chk(req_lock, "R10 lock held while queued", req_lock, 1);
        rmode = mode;
        wait_done(2000);
    endtask

    // Monitor
    int  cyc = 0, vstart = 0, last_act = 0, last_wr = 0, last_rw = 0, close_ok = 0;
    bit  seen_act = 0, seen_wr = 0, seen_rw = 0, pend = 0, ref_hold = 0;
    int  gap_act_act = -1, gap_wr_pre = -1, gap_act_pre = -1, gap_act_rw = -1;

    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] code;
            bit hs, hsw, hsr;
            cyc++;
            code = {cmd_cas, cmd_ras, cmd_we};
            hs   = cmd_valid && cmd_ready;
            hsw  = hs && code == C_WR;
            hsr  = hs && code == C_RD;
            if (ref_hold && cmd_valid) chk(0, "R9 command during refresh", code, 0);
            if (cmd_valid && !pend) begin
                vstart = cyc;
                if (code == C_ACT && seen_act) begin
                    chk(cyc - last_act >= T_RC, "R8 tRC", cyc - last_act, T_RC);
                    chk(cyc >= close_ok, "R8 tRP", cyc, close_ok);
                end
                if (code == C_PRE) begin
                    chk(cyc - last_act >= T_RAS, "R8 tRAS", cyc - last_act, T_RAS);
                    if (seen_wr) chk(cyc - last_wr >= GAP_WP, "R7 write to precharge", cyc - last_wr, GAP_WP);
                end
                if (code == C_RD || code == C_WR) begin
                    chk(cyc - last_act >= T_RCD, "R8 tRCD", cyc - last_act, T_RCD);
                    if (seen_rw) chk(cyc - last_rw >= T_CCD, "R8 tCCD", cyc - last_rw, T_CCD);
                end
            end
            if (req_wdata_ready || hsw) chk(req_wdata_ready == hsw, "R11 write strobe", req_wdata_ready, hsw);
            if (req_rdata_valid || hsr) chk(req_rdata_valid == hsr, "R11 read strobe", req_rdata_valid, hsr);
            if (hs) begin
                chk($countones({cmd_is_cmd, cmd_is_read, cmd_is_write}) == 1
                    && cmd_is_cmd == (code == C_ACT || code == C_PRE)
                    && cmd_is_read == (code == C_RD) && cmd_is_write == (code == C_WR),
                    "R1 flags", {cmd_is_cmd, cmd_is_read, cmd_is_write}, code);
                chk(cmd_ba == BANK_W'(BANK_IDX), "R2 bank index", cmd_ba, BANK_IDX);
                if (q_code.size() == 0) chk(0, "R4 unexpected command", code, 0);
                else begin
                    logic [2:0] ec;
                    logic [A_W-1:0] ea;
                    ec = q_code.pop_front(); ea = q_addr.pop_front();
                    chk(code == ec, "R4 R5 R6 command order", code, ec);
                    chk(cmd_a == ea, "R3 command address", cmd_a, ea);
                end
                case (code)
                    C_ACT: begin
                        if (seen_act) gap_act_act = vstart - last_act;
                        last_act = cyc; seen_act = 1;
                    end
                    C_PRE: begin
                        gap_wr_pre = vstart - last_wr; gap_act_pre = vstart - last_act;
                        close_ok = cyc + T_RP;
                    end
                    default: begin
                        gap_act_rw = vstart - last_act;
                        last_rw = cyc; seen_rw = 1;
                        if (code == C_WR) begin last_wr = cyc; seen_wr = 1; end
                        if (cmd_a[10]) close_ok = cyc + ((code == C_WR) ? GAP_APW : T_RP);
                    end
                endcase
            end
            pend = cmd_valid && !cmd_ready;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; req_valid = 0; req_we = 0; req_addr = '0; refresh_req = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!cmd_valid, "R1 no command in reset", cmd_valid, 0);
        chk(req_ready, "R12 ready after reset", req_ready, 1);
        chk(!req_lock, "R10 lock low after reset", req_lock, 0);
        chk(!refresh_gnt, "R9 no grant after reset", refresh_gnt, 0);
        @(posedge clk); #1 rst = 0;

        // Write to one row, then another: exact R7, tRC and tRCD gaps
        b_we[0] = 1; b_row[0] = 13'h0ba; b_col[0] = 8'h0d;
        run_batch(1, 1);
        chk(gap_act_rw == T_RCD, "R8 exact tRCD", gap_act_rw, T_RCD);
        b_we[0] = 1; b_row[0] = 13'h0da; b_col[0] = 8'h0d;
        run_batch(1, 1);
        chk(gap_wr_pre == GAP_WP, "R7 exact write to precharge", gap_wr_pre, GAP_WP);
        chk(gap_act_act == T_RC, "R8 exact tRC", gap_act_act, T_RC);

        // Reads on two rows: tRAS limits the precharge
        b_we[0] = 0; b_row[0] = 13'h111; b_col[0] = 8'h01;
        run_batch(1, 1);
        b_we[0] = 0; b_row[0] = 13'h222; b_col[0] = 8'h02;
        run_batch(1, 1);
        chk(gap_act_pre == T_RAS, "R8 exact tRAS", gap_act_pre, T_RAS);

        // Same-row reuse (R4) then lookahead auto-precharge (R5)
        b_we[0] = 0; b_row[0] = 13'h222; b_col[0] = 8'had;
        b_we[1] = 1; b_row[1] = 13'h222; b_col[1] = 8'had;
        b_we[2] = 0; b_row[2] = 13'h222; b_col[2] = 8'hbe;
        b_we[3] = 1; b_row[3] = 13'h222; b_col[3] = 8'hbe;
        run_batch(4, 2);
        b_we[0] = 1; b_row[0] = 13'h0ba; b_col[0] = 8'h10;
        b_we[1] = 1; b_row[1] = 13'h0da; b_col[1] = 8'h11;
        b_we[2] = 0; b_row[2] = 13'h0da; b_col[2] = 8'h12;
        run_batch(3, 1);

        // Random batches
        for (int t = 0; t < 24; t++) begin
            int n;
            n = 1 + ($urandom % 4);
            for (int i = 0; i < n; i++) begin
                int r;
                r = $urandom % 3;
                b_we[i]  = $urandom % 2;
                b_row[i] = (r == 0) ? 13'h0ba : (r == 1) ? 13'h0da : 13'h1ff;
                b_col[i] = CA_W'($urandom);
            end
            run_batch(n, (t % 3 == 0) ? 1 : 2);
        end

        // Refresh with requests queued behind it (R9)
        rmode = 1;
        @(posedge clk); #1 refresh_req = 1;
        if (m_open) begin q_code.push_back(C_PRE); q_addr.push_back('0); end
        m_open = 0;
        begin
            int k = 0;
            do begin @(negedge clk); k++; end while (!refresh_gnt && k < 200);
            chk(refresh_gnt, "R9 grant after close", refresh_gnt, 1);
            chk(q_code.size() == 0, "R9 row closed before grant", q_code.size(), 0);
        end
        ref_hold = 1;
        b_we[0] = 1; b_row[0] = 13'h0ba; b_col[0] = 8'h21;
        b_we[1] = 1; b_row[1] = 13'h0ba; b_col[1] = 8'h22;
        model_batch(2);
        push_req(b_we[0], b_row[0], b_col[0]);
        push_req(b_we[1], b_row[1], b_col[1]);
        repeat (20) @(negedge clk);
        chk(req_lock, "R10 lock held during refresh", req_lock, 1);
        chk(refresh_gnt, "R9 grant held", refresh_gnt, 1);
        @(posedge clk); #1 refresh_req = 0; ref_hold = 0;
        wait_done(500);

        // Back-to-back burst with a full queue (R12)
        for (int i = 0; i < 10; i++) begin
            b_we[i] = 1; b_row[i] = 13'h0ba; b_col[i] = CA_W'(i);
        end
        model_batch(10);
        rmode = 0;
        for (int i = 0; i < QD; i++) push_req(b_we[i], b_row[i], b_col[i]);
        @(negedge clk);
        chk(!req_ready, "R12 ready low when queue full", req_ready, 0);
        rmode = 2;
        for (int i = QD; i < 10; i++) push_req(b_we[i], b_row[i], b_col[i]);
        wait_done(2000);

        repeat (5) @(negedge clk);
        chk(!cmd_valid, "R4 idle after last request", cmd_valid, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule